// File: doc/BRIEF.md
# FEC Error Statistics Interval Monitor

This block sits beside a streaming forward-error-correction decoder that works on a framed stream. The stream is organised as four rows of a programmable number of columns. On every clock the block sees the word as it was received, the word after correction, a flag that marks an uncorrectable codeword, the row and column position, and a data-valid strobe. From these it keeps five statistics:

- bits corrected from 0 to 1
- bits corrected from 1 to 0
- the total of corrected bits
- uncorrectable codewords
- complete frames

A single latch pulse closes the current measurement interval. All five interval counts then move together into registered outputs, and the next interval starts counting. Software or a performance-monitoring sequencer pulses the latch at a fixed rate and reads the frozen outputs between pulses. The word width is a parameter, so the block can be simulated at a small width. The counter width defaults to 32 bits.

Top module: `fecstat_monitor`

## Requirements
- R1: An active-high asynchronous reset clears all five outputs and all running counts to 0 at once, with no clock edge needed.
- R2: When `latch` is high in the cycle before clock edge N, each output takes its interval count at edge N+1. Each output then keeps that value until the next latch pulse takes effect.
- R3: `zero_errs` counts the bit positions that are 0 in `rx_data` and 1 in `corr_data`, summed over valid cycles.
- R4: `one_errs` counts the bit positions that are 1 in `rx_data` and 0 in `corr_data`, summed over valid cycles.
- R5: `total_errs` counts every bit position in which `rx_data` and `corr_data` differ, summed over valid cycles.
- R6: `uncorr_count` counts the valid cycles in which `uncorrectable` is 1.
- R7: `frame_count` counts the valid cycles in which `row` equals 3 and `col` equals `max_col`.
- R8: While `enable_n` is 1, no statistic is counted. Latch pulses still transfer the counts, so an interval spent wholly disabled reads 0 on every output.
- R9: A cycle with `data_valid` at 0 adds nothing to any statistic, whatever the data and flags show.
- R10: An event in the same cycle as a latch pulse goes into the new interval. The running count restarts at that cycle's increment, not at 0.
- R11: A running count that reaches all ones (2^CNT_W-1) stays there until the next latch pulse; it never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable_n | input | 1 | Counting enable, active low, synchronous |
| max_col | input | 8 | Index of the last column in a row |
| row | input | 2 | Row index of the current word |
| col | input | 8 | Column index of the current word |
| data_valid | input | 1 | The current word is valid |
| rx_data | input | DATA_W | Word as received |
| corr_data | input | DATA_W | Word after correction |
| uncorrectable | input | 1 | The codeword ending here could not be corrected |
| latch | input | 1 | Interval latch pulse, active high, synchronous |
| zero_errs | output | CNT_W | Latched count of 0-to-1 corrections |
| one_errs | output | CNT_W | Latched count of 1-to-0 corrections |
| total_errs | output | CNT_W | Latched count of all corrected bits |
| uncorr_count | output | CNT_W | Latched count of uncorrectable codewords |
| frame_count | output | CNT_W | Latched count of complete frames |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that the per-cycle increment can never exceed the counter range, which holds when CNT_W is at least the increment width. The stimulus changes inputs only on the falling clock edge. It keeps `row` and `col` in step with a frame position counter that wraps at `max_col`, and it changes `max_col` only once, when a row has just completed. The bench uses CNT_W of 12 so that a run of fully corrupted words drives the counters into saturation within a few hundred cycles.

// File: rtl/fecstat_pkg.sv
package fecstat_pkg;
  localparam int NUM_STATS = 5;
  localparam int IDX_ZERO  = 0;
  localparam int IDX_ONE   = 1;
  localparam int IDX_TOTAL = 2;
  localparam int IDX_UNC   = 3;
  localparam int IDX_FRAME = 4;
  localparam logic [1:0] LAST_ROW = 2'd3;
endpackage

// File: rtl/fecstat_popcnt.sv
module fecstat_popcnt #(
  parameter int W  = 640,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + OW'(bits[i]);
    end
  end
endmodule

// File: rtl/fecstat_errmask.sv
module fecstat_errmask #(
  parameter int DATA_W = 640,
  parameter int PC_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] corr_data,
  output logic [PC_W-1:0]   zero_cnt,
  output logic [PC_W-1:0]   one_cnt
);
  logic [1:0][DATA_W-1:0] masks;
  logic [1:0][PC_W-1:0]   counts;

  // mask 0: received 0, corrected to 1; mask 1: received 1, corrected to 0
  assign masks[0] = ~rx_data &  corr_data;
  assign masks[1] =  rx_data & ~corr_data;

  for (genvar m = 0; m < 2; m++) begin : g_pop
    fecstat_popcnt #(.W(DATA_W), .OW(PC_W)) u_pop (
      .bits  (masks[m]),
      .count (counts[m])
    );
  end

  assign zero_cnt = counts[0];
  assign one_cnt  = counts[1];
endmodule

// File: rtl/fecstat_stage.sv
module fecstat_stage
  import fecstat_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int INC_W = PC_W + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              enable_n,
  input  logic                              data_valid,
  input  logic                              uncorrectable,
  input  logic [1:0]                        row,
  input  logic [7:0]                        col,
  input  logic [7:0]                        max_col,
  input  logic                              latch,
  input  logic [PC_W-1:0]                   zero_cnt,
  input  logic [PC_W-1:0]                   one_cnt,
  output logic [NUM_STATS-1:0][INC_W-1:0]   inc_q,
  output logic                              latch_q
);
  logic count_ok;
  logic frame_hit;

  assign count_ok  = data_valid & ~enable_n;
  assign frame_hit = count_ok && (row == LAST_ROW) && (col == max_col);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      inc_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= latch;
      if (count_ok) begin
        inc_q[IDX_ZERO]  <= INC_W'(zero_cnt);
        inc_q[IDX_ONE]   <= INC_W'(one_cnt);
        inc_q[IDX_TOTAL] <= INC_W'(zero_cnt) + INC_W'(one_cnt);
        inc_q[IDX_UNC]   <= INC_W'(uncorrectable);
      end else begin
        inc_q[IDX_ZERO]  <= '0;
        inc_q[IDX_ONE]   <= '0;
        inc_q[IDX_TOTAL] <= '0;
        inc_q[IDX_UNC]   <= '0;
      end
      inc_q[IDX_FRAME] <= INC_W'(frame_hit);
    end
  end

  // R8: disabled cycles feed nothing into the counters
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (rst)
    enable_n |=> (inc_q == '0));

  // R9: invalid cycles feed nothing into the counters
  a_r9_valid_gate: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> (inc_q == '0));
endmodule

// File: rtl/fecstat_accum.sv
module fecstat_accum #(
  parameter int INC_W = 12,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] out_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] acc_d;

  assign base  = latch ? '0 : acc_q;
  assign sum   = {1'b0, base} + (CNT_W + 1)'(inc);
  assign acc_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (latch) out_q <= acc_q;
    end
  end

  // R2: outputs hold between latch pulses
  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(out_q));

  // R2: a latch moves the closed interval's count to the output
  a_r2_transfer: assert property (@(posedge clk) disable iff (rst)
    latch |=> (out_q == $past(acc_q)));

  // R10: the new interval restarts at the coincident increment
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    latch |=> (acc_q == CNT_W'($past(inc))));

  // R11: a saturated count never wraps inside an interval
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!latch && acc_q == CNT_MAX) |=> (acc_q == CNT_MAX));
endmodule

// File: rtl/fecstat_monitor.sv
module fecstat_monitor
  import fecstat_pkg::*;
#(
  parameter int DATA_W = 640,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_n,
  input  logic [7:0]        max_col,
  input  logic [1:0]        row,
  input  logic [7:0]        col,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] corr_data,
  input  logic              uncorrectable,
  input  logic              latch,
  output logic [CNT_W-1:0]  zero_errs,
  output logic [CNT_W-1:0]  one_errs,
  output logic [CNT_W-1:0]  total_errs,
  output logic [CNT_W-1:0]  uncorr_count,
  output logic [CNT_W-1:0]  frame_count
);
  localparam int PC_W  = $clog2(DATA_W + 1);
  localparam int INC_W = PC_W + 1;

  logic [PC_W-1:0]                 zero_cnt;
  logic [PC_W-1:0]                 one_cnt;
  logic [NUM_STATS-1:0][INC_W-1:0] inc;
  logic                            latch_d;
  logic [NUM_STATS-1:0][CNT_W-1:0] stats;

  fecstat_errmask #(.DATA_W(DATA_W), .PC_W(PC_W)) u_mask (
    .rx_data   (rx_data),
    .corr_data (corr_data),
    .zero_cnt  (zero_cnt),
    .one_cnt   (one_cnt)
  );

  fecstat_stage #(.PC_W(PC_W), .INC_W(INC_W)) u_stage (
    .clk           (clk),
    .rst           (rst),
    .enable_n      (enable_n),
    .data_valid    (data_valid),
    .uncorrectable (uncorrectable),
    .row           (row),
    .col           (col),
    .max_col       (max_col),
    .latch         (latch),
    .zero_cnt      (zero_cnt),
    .one_cnt       (one_cnt),
    .inc_q         (inc),
    .latch_q       (latch_d)
  );

  for (genvar s = 0; s < NUM_STATS; s++) begin : g_stat
    fecstat_accum #(.INC_W(INC_W), .CNT_W(CNT_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .latch (latch_d),
      .inc   (inc[s]),
      .out_q (stats[s])
    );
  end

  assign zero_errs    = stats[IDX_ZERO];
  assign one_errs     = stats[IDX_ONE];
  assign total_errs   = stats[IDX_TOTAL];
  assign uncorr_count = stats[IDX_UNC];
  assign frame_count  = stats[IDX_FRAME];

  // R1: reset leaves every output at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |-> (stats == '0));
endmodule

// File: tb/fecstat_monitor_test.sv
module fecstat_monitor_test;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam longint MAXC = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_n = 1'b0;
  logic [7:0] max_col = 8'd5;
  logic [1:0] row = '0;
  logic [7:0] col = '0;
  logic data_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] corr_data = '0;
  logic uncorrectable = 1'b0;
  logic latch = 1'b0;
  logic [CW-1:0] o_stat [5];

  always #2 clk = ~clk;

  fecstat_monitor #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .enable_n(enable_n), .max_col(max_col),
    .row(row), .col(col), .data_valid(data_valid), .rx_data(rx_data),
    .corr_data(corr_data), .uncorrectable(uncorrectable), .latch(latch),
    .zero_errs(o_stat[0]), .one_errs(o_stat[1]), .total_errs(o_stat[2]),
    .uncorr_count(o_stat[3]), .frame_count(o_stat[4])
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";
  string stag [5] = '{"R3", "R4", "R5", "R6", "R7"};

  longint macc [5];
  longint mout [5];
  longint pinc [5];
  bit plat;

  task automatic model_edge();
    if (rst) begin
      for (int s = 0; s < 5; s++) begin macc[s] = 0; mout[s] = 0; pinc[s] = 0; end
      plat = 0;
    end else begin
      for (int s = 0; s < 5; s++) begin
        if (plat) begin mout[s] = macc[s]; macc[s] = pinc[s]; end
        else macc[s] = (macc[s] + pinc[s] > MAXC) ? MAXC : macc[s] + pinc[s];
      end
      plat = latch;
      if (data_valid && !enable_n) begin
        pinc[0] = $countones(~rx_data & corr_data);
        pinc[1] = $countones(rx_data & ~corr_data);
        pinc[2] = $countones(rx_data ^ corr_data);
        pinc[3] = uncorrectable;
        pinc[4] = (row == 2'd3 && col == max_col) ? 1 : 0;
      end else begin
        for (int s = 0; s < 5; s++) pinc[s] = 0;
      end
    end
  endtask

  task automatic compare();
    for (int s = 0; s < 5; s++) begin
      checks++;
      if (longint'(o_stat[s]) != mout[s]) begin
        errors++;
        $display("FAIL %s/%s stat %0d: actual %0d expected %0d", phase, stag[s], s, o_stat[s], mout[s]);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  // one stream word: flips chosen per bit, position advances when valid
  task automatic word(bit v, logic [DW-1:0] flips, bit unc, bit lat);
    data_valid = v;
    rx_data = DW'($urandom);
    corr_data = rx_data ^ flips;
    uncorrectable = unc;
    latch = lat;
    tick();
    if (v) begin
      if (col == max_col) begin col = 0; row = row + 2'd1; end
      else col = col + 8'd1;
    end
  endtask

  task automatic interval(int n, bit vrand, int flipmode);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] f;
      f = (flipmode == 2) ? '1 : (flipmode == 1) ? DW'($urandom & $urandom) : '0;
      word(vrand ? 1'($urandom) : 1'b1, f, 1'($urandom % 3 == 0), 1'b0);
    end
    word(1'b1, DW'($urandom & $urandom), 1'b1, 1'b1);
  endtask

  initial begin
    for (int s = 0; s < 5; s++) begin macc[s] = 0; mout[s] = 0; pinc[s] = 0; end
    plat = 0;
    repeat (3) tick();
    rst = 1'b0;
    phase = "R1";
    tick();
    phase = "R2";
    repeat (4) interval(30, 0, 1);
    phase = "R9";
    repeat (3) interval(40, 1, 1);
    phase = "R8";
    enable_n = 1'b1;
    interval(25, 0, 1);
    interval(25, 0, 1);
    enable_n = 1'b0;
    phase = "R7";
    while (!(row == 2'd0 && col == 8'd0)) word(1'b1, '0, 1'b0, 1'b0);
    max_col = 8'd9;
    repeat (3) interval(60, 0, 0);
    phase = "R10";
    for (int k = 0; k < 6; k++) interval(k, 0, 1);
    phase = "R11";
    interval(300, 0, 2);
    interval(5, 0, 1);
    repeat (3) tick();
    phase = "R1";
    @(negedge clk);
    rst = 1'b1;
    #1;
    for (int s = 0; s < 5; s++) begin
      checks++;
      if (o_stat[s] != '0) begin
        errors++;
        $display("FAIL R1 async clear stat %0d: actual %0d expected 0", s, o_stat[s]);
      end
    end
    tick();
    rst = 1'b0;
    tick();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule